// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output Generator

This block drives a clock output pin from a 48 MHz reference. The output period is N+1 reference cycles, where N is a 4-bit division factor that firmware loads with a one-cycle write strobe. After reset N is 11, so the pin runs at 4 MHz until firmware picks another rate. The range runs from 48 MHz (N = 0) down to 4 MHz (N = 11). A written value above 11 is treated as 11. A newly written factor waits until the running output period has finished, so a change of rate never cuts a pulse short.

To save power during suspend, the block can move the pin over to a slow clock of roughly 30 kHz. This happens only when the no-lazy-clock bit is clear, and only after the suspend indication has stayed high for 1 ms, which is 48,000 reference cycles. When suspend drops, the block goes back to the divided clock straight away. A handshaked mux moves the pin between the two sources. Each source is gated off only while it is low, and the other source is let through only after that. The register that holds the factor is cleared only by the block's reset. A USB bus reset is not connected to this block.

All pins are plain level or strobe signals. No streaming interface is involved.

Top module: `clkout_gen`

## Requirements
- R1: While rst_n is low, clk_out is held low. After reset the held factor is 11, so clk_out has a period of 12 reference cycles and is high for 6 of them.
- R2: For a held factor N from 1 to 11, the period of clk_out is N+1 reference cycles. The high phase lasts ceil((N+1)/2) cycles and the low phase floor((N+1)/2) cycles.
- R3: With factor 0, clk_out follows the reference clock: the period is one reference cycle and the output is high for half a cycle.
- R4: A written factor from 12 to 15 acts exactly like 11.
- R5: A factor written with div_wr (sampled at a rising reference edge) takes effect only after the output period in progress has completed.
- R6: No high or low phase of clk_out ever lasts less than half a reference period, including at changes of factor.
- R7: With no_lazy = 0, clk_out keeps its divided period for 48,000 reference cycles after suspend rises. After that it carries slow_clk.
- R8: With no_lazy = 1, suspend has no effect: clk_out keeps its divided period.
- R9: When suspend falls, clk_out returns to the divided clock within a few slow_clk periods.
- R10: No high or low phase shorter than half a reference period occurs when the pin switches between the divided clock and slow_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware or power-on reset |
| div_wr | input | 1 | One-cycle strobe that loads div_factor |
| div_factor | input | 4 | Division factor N; the output period is N+1 cycles |
| no_lazy | input | 1 | 1 keeps the divided clock on the pin during suspend |
| suspend | input | 1 | Suspend indication, asynchronous |
| slow_clk | input | 1 | Slow clock of about 30 kHz used during suspend |
| clk_out | output | 1 | Output clock |

## Verification
A wrong counter or a wrongly held factor shows up as a wrong period length or duty cycle on clk_out. It appears within one or two output periods after a write, and the bench measures this edge to edge. A factor applied too early gives a shortened current period, which is visible at the very next rising edge. A broken source handshake shows up as a runt phase at the moment of the switch, and a continuous width monitor catches it. A wrong suspend delay shows up as a switch that comes too early or too late relative to the 48,000-cycle window.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int FACTOR_W   = 4;
  localparam int MAX_FACTOR = 11;
  localparam int LAZY_DELAY = 48000;
endpackage

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int FW   = clkout_pkg::FACTOR_W,
  parameter int MAXF = clkout_pkg::MAX_FACTOR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [FW-1:0] factor,
  output logic          div_clk
);
  localparam logic [FW-1:0] MAXV = FW'(MAXF);

  logic [FW-1:0] pend_q, cur_q, cnt_q, clamped, cnt_nx;
  logic [FW:0]   hi_len;
  logic          out_q, byp_q, gate_q, wrap;

  assign clamped = (factor > MAXV) ? MAXV : factor;
  assign wrap    = (cnt_q == cur_q);
  assign cnt_nx  = cnt_q + 1'b1;
  assign hi_len  = ({1'b0, cur_q} + 2'd2) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= MAXV;
    else if (wr) pend_q <= clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MAXV;
      cnt_q <= MAXV;
      out_q <= 1'b0;
      byp_q <= 1'b0;
    end else if (wrap) begin
      cur_q <= pend_q;
      cnt_q <= '0;
      out_q <= (pend_q != '0);
      byp_q <= (pend_q == '0);
    end else begin
      cnt_q <= cnt_nx;
      out_q <= ({1'b0, cnt_nx} < hi_len);
    end
  end

  // enable latched while the reference is low, so the gated path never chops a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else gate_q <= byp_q;
  end

  assign div_clk = out_q | (clk & gate_q);

  // R4
  factor_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n) cur_q <= MAXV);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= cur_q);
  // R5
  load_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> !$past(out_q));
  // R3
  bypass_low_chk: assert property (@(posedge clk) disable iff (!rst_n) byp_q |-> !out_q);
endmodule

// File: rtl/clkout_susp_timer.sv
module clkout_susp_timer #(
  parameter int DELAY = clkout_pkg::LAZY_DELAY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend,
  input  logic no_lazy,
  output logic lazy_sel
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic          s0_q, s1_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s0_q, s1_q} <= 2'b00;
    else {s0_q, s1_q} <= {suspend, s0_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!s1_q) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign lazy_sel = s1_q & ~no_lazy & (cnt_q == LIMIT);

  // R9
  exit_now_chk: assert property (@(posedge clk) disable iff (!rst_n) !$past(s1_q) |-> !lazy_sel);
  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LIMIT);
endmodule

// File: rtl/clkout_glitch_mux.sv
module clkout_glitch_mux (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  output logic clk_o
);
  logic a_s1, a_en, b_s1, b_en;

  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= 1'b1;
      a_en <= 1'b1;
    end else begin
      a_s1 <= ~sel_b & ~b_en & ~b_s1;
      a_en <= a_s1;
    end
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      b_s1 <= 1'b0;
      b_en <= 1'b0;
    end else begin
      b_s1 <= sel_b & ~a_en & ~a_s1;
      b_en <= b_s1;
    end
  end

  assign clk_o = (clk_a & a_en) | (clk_b & b_en);

  always_comb begin
    if (rst_n === 1'b1) begin
      // R10
      src_excl_chk: assert (!(a_en && b_en));
    end
  end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int FW    = clkout_pkg::FACTOR_W,
  parameter int MAXF  = clkout_pkg::MAX_FACTOR,
  parameter int DELAY = clkout_pkg::LAZY_DELAY
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          div_wr,
  input  logic [FW-1:0] div_factor,
  input  logic          no_lazy,
  input  logic          suspend,
  input  logic          slow_clk,
  output logic          clk_out
);
  logic div_clk, lazy_sel;

  clkout_div #(.FW(FW), .MAXF(MAXF)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .wr(div_wr), .factor(div_factor), .div_clk(div_clk)
  );

  clkout_susp_timer #(.DELAY(DELAY)) u_timer (
    .clk(clk_ref), .rst_n(rst_n), .suspend(suspend), .no_lazy(no_lazy), .lazy_sel(lazy_sel)
  );

  clkout_glitch_mux u_mux (
    .rst_n(rst_n), .clk_a(div_clk), .clk_b(slow_clk), .sel_b(lazy_sel), .clk_o(clk_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_ref) !rst_n |-> !clk_out);
endmodule

// File: tb/clkout_gen_test.sv
`timescale 1ns/1ps
module clkout_gen_test;
  localparam int TCK  = 20;
  localparam int TSLW = 640;

  logic       clk = 0, slow = 0, rst_n = 0, wr = 0, no_lazy = 0, suspend = 0;
  logic [3:0] fac = 0;
  logic       clk_out;
  int errors = 0, checks = 0, runts = 0;
  bit done = 0, armed = 0;
  time last_edge = 0;

  always #(TCK/2) clk = ~clk;
  always #(TSLW/2) slow = ~slow;

  clkout_gen uut (.clk_ref(clk), .rst_n(rst_n), .div_wr(wr), .div_factor(fac),
                  .no_lazy(no_lazy), .suspend(suspend), .slow_clk(slow), .clk_out(clk_out));

  // continuous width monitor (R6, R10)
  always @(clk_out) begin
    if (armed && ($time - last_edge) < TCK/2) begin
      runts++;
      $display("FAIL R6/R10 runt phase width=%0t expected>=%0d", $time - last_edge, TCK/2);
    end
    last_edge = $time;
  end

  function automatic int exp_period(input int f);
    int n = (f > 11) ? 11 : f;
    return (n + 1) * TCK;
  endfunction

  function automatic int exp_high(input int f);
    int n = (f > 11) ? 11 : f;
    return (n == 0) ? TCK/2 : ((n + 2) / 2) * TCK;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output longint per, output longint hi);
    time a, b, c;
    @(posedge clk_out); a = $time;
    @(negedge clk_out); b = $time;
    @(posedge clk_out); c = $time;
    per = c - a; hi = b - a;
  endtask

  task automatic write_factor(input logic [3:0] f);
    @(negedge clk); fac = f; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    longint p, h;
    time t0, t1, t2;
    void'($urandom(32'd2024));
    // R1 reset state
    repeat (3) begin
      #7; check("R1 clk_out low in reset", clk_out, 0);
    end
    @(negedge clk); rst_n = 1; armed = 1;
    measure(p, h);
    check("R1 reset period", p, 12*TCK);
    check("R1 reset high", h, 6*TCK);

    // R2 directed sweep
    for (int f = 1; f <= 11; f++) begin
      write_factor(4'(f));
      repeat (30) @(posedge clk);
      measure(p, h);
      check("R2 period", p, exp_period(f));
      check("R2 high", h, exp_high(f));
    end

    // R3 factor zero
    write_factor(4'd0);
    repeat (30) @(posedge clk);
    measure(p, h);
    check("R3 period", p, TCK);
    check("R3 high", h, TCK/2);

    // R4 clamp
    write_factor(4'd15);
    repeat (30) @(posedge clk);
    measure(p, h);
    check("R4 period for 15", p, 12*TCK);

    // R5 change waits for end of current period
    repeat (30) @(posedge clk);
    @(posedge clk_out); t0 = $time;
    #1; write_factor(4'd3);
    @(posedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    check("R5 old period finishes", t1 - t0, 12*TCK);
    check("R5 new period", t2 - t1, 4*TCK);

    // random factors at random phases
    for (int i = 0; i < 20; i++) begin
      int f = $urandom_range(15, 0);
      repeat ($urandom_range(7, 0)) @(posedge clk);
      write_factor(4'(f));
      repeat (30) @(posedge clk);
      measure(p, h);
      check((f > 11) ? "R4 random period" : "R2 random period", p, exp_period(f));
      check("R2 random high", h, exp_high(f));
    end

    // R7 suspend with lazy clock allowed
    write_factor(4'd3);
    repeat (30) @(posedge clk);
    no_lazy = 0; #3; suspend = 1;
    repeat (47000) @(posedge clk);
    measure(p, h);
    check("R7 divided before delay", p, 4*TCK);
    repeat (1100) @(posedge clk);
    repeat (4) @(posedge slow);
    measure(p, h);
    check("R7 slow clock period", p, TSLW);
    check("R7 slow clock high", h, TSLW/2);

    // R9 leave suspend
    #3; suspend = 0;
    repeat (6) @(posedge slow);
    repeat (10) @(posedge clk);
    measure(p, h);
    check("R9 back to divided", p, 4*TCK);

    // R8 no_lazy set: suspend ignored
    no_lazy = 1; #3; suspend = 1;
    repeat (49000) @(posedge clk);
    measure(p, h);
    check("R8 no lazy period", p, 4*TCK);
    check("R8 no lazy high", h, 2*TCK);
    suspend = 0;
    repeat (20) @(posedge clk);

    check("R6 no runt phases", runts, 0);
    check("R10 no runt at switch", runts, 0);
    done = 1;
    summary();
  end
endmodule